// File: doc/BRIEF.md
# Pulse-Width-Selected Cascaded Low-Pass Filter Bank

This block low-pass filters a stream of complex baseband samples (an in-phase and a quadrature word per sample) through a chain of three FIR stages with decimators between them. A radar pulse's width class is given on a 3-bit one-hot select. Short pulses take their result straight from the wide first stage. Medium pulses go on through a decimate-by-5 and a second stage. Long pulses continue through a further decimate-by-10 and a third, narrowest stage. All three stages share one chain, so one set of filters serves all three classes. Stages beyond the selected depth are disabled and hold their state.

Samples enter on a valid/ready stream and results leave on a valid/ready stream through a single-entry output register. The upstream side sees back-pressure (`in_ready` low) for as long as a result sits in that register unaccepted. It also sees back-pressure for the one cycle in which the select changes. Every accepted sample advances the first stage. A result is offered only when the selected stage produces a new, fully settled output. When the select changes, every stage that becomes newly enabled starts again from an empty history. Results stay suppressed until those stages have refilled.

Top module: `pw_cascade_filter`

## Requirements
- R1: After reset `out_valid` is 0, and with the select held at 000 `in_ready` is 1.
- R2: The select is one-hot. 001 routes stage 1 to the output, 010 routes stage 2 (stages 1 and 2 enabled), and 100 routes stage 3 (all stages enabled). Any other value enables no stage and keeps `out_valid` at 0. Samples are still accepted (`in_ready` 1) and discarded.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid`, `out_i` and `out_q` hold. Once the result is taken, `in_ready` returns to 1.
- R4: A result caused by an accepted sample is visible on the outputs from the rising edge that accepts the sample. Zero extra register stages.
- R5: Each stage is a 16-tap FIR. The newest sample's coefficient is 1, and the coefficient of the sample k places older is 2k+1 for k<8 and 2(15-k)+1 for k>=8. The sum is divided by 128. So an impulse of 1280 into a cleared stage 1 yields 10, 30, 50 … 150, 150 … 30, 10 on consecutive samples, then 0.
- R6: Every stage has unity DC gain. A constant input that fills the chain yields that same constant at the output of the selected stage.
- R7: Once settled, results appear on every accepted sample for select 001, every 5th for 010, and every 50th for 100.
- R8: After all stages are cleared, the first result appears on accepted sample 16 (select 001), 91 (select 010) or 841 (select 100). No result appears before that.
- R9: In the cycle the select changes, `in_ready` is 0 and any pending result is discarded (`out_valid` is 0 the next cycle). Newly enabled stages are cleared. Stages that stay enabled keep their history: after 100 → 001, the next sample gives a result at once.
- R10: Division by 128 rounds halves toward positive infinity and saturates to 16 bits. An impulse of 64 gives 1, and one of −64 gives 0. On the next sample the results are 2 and −1.
- R11: The I and Q paths are identical and independent. Opposite inputs give opposite results in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | One-hot pulse-width class select |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle when `in_valid` is also 1 |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| out_valid | output | 1 | Filtered result present |
| out_ready | input | 1 | Downstream takes the result |
| out_i | output | 16 | Filtered in-phase result |
| out_q | output | 16 | Filtered quadrature result |

## Verification
Each result is due one edge after the sample that causes it. Each bench transfer drives a sample on a falling edge and lets the next rising edge accept it. It reads `out_valid` and the data on the following falling edge, so every check looks at the register loaded by that exact acceptance. Refill depth is checked by counting accepted samples to the first result: the 16th, 91st and 841st. Decimation is checked by the spacing of later results: every sample, every 5th and every 50th. A select change is observed on the falling edge where it is applied (`in_ready` low) and on the next one (pending result gone, input open again).

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Number of cascaded stages; also the width of the one-hot select.
  localparam int NSTAGE = 3;

  // Symmetric triangular tap weight: 2k+1 rising to the centre, mirrored after it.
  function automatic int tap_coef(input int j, input int ntaps);
    int k;
    k = (j < ntaps / 2) ? j : ntaps - 1 - j;
    return 2 * k + 1;
  endfunction

  // Stages switched on by a select value; zero for anything not one-hot.
  function automatic logic [NSTAGE-1:0] stage_enables(input logic [NSTAGE-1:0] s);
    case (s)
      3'b001:  return 3'b001;
      3'b010:  return 3'b011;
      3'b100:  return 3'b111;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwc_fir_lane.sv
module pwc_fir_lane
  import pwc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NTAPS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  localparam int HALF = NTAPS / 2;
  localparam int SH   = $clog2(NTAPS * NTAPS / 2);
  localparam int AW   = DW + $clog2(NTAPS * NTAPS) + 2;
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  // hist[0] is the previous sample, hist[NTAPS-2] the oldest kept.
  logic signed [DW-1:0] hist [NTAPS-1];
  logic signed [DW-1:0] win  [NTAPS];
  logic signed [AW-1:0] acc, rnd, shf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NTAPS - 1; j++) hist[j] <= '0;
    end else if (clr) begin
      for (int j = 0; j < NTAPS - 1; j++) hist[j] <= '0;
    end else if (tick) begin
      hist[0] <= din;
      for (int j = 1; j < NTAPS - 1; j++) hist[j] <= hist[j-1];
    end
  end

  // Window seen by the result of this tick: the new sample plus the history.
  always_comb begin
    win[0] = din;
    for (int j = 1; j < NTAPS; j++) win[j] = hist[j-1];
  end

  // Mirror taps share a coefficient: pre-add the pair, one product per pair.
  always_comb begin
    acc = '0;
    for (int j = 0; j < HALF; j++) begin
      acc = acc + AW'(tap_coef(j, NTAPS)) * (AW'(win[j]) + AW'(win[NTAPS-1-j]));
    end
    rnd = acc + (AW'(1) <<< (SH - 1));
    shf = rnd >>> SH;
    if (shf > MAXV)      dout = MAXV[DW-1:0];
    else if (shf < MINV) dout = MINV[DW-1:0];
    else                 dout = shf[DW-1:0];
  end

endmodule

// File: rtl/pwc_stage.sv
module pwc_stage #(
  parameter int DW    = 16,
  parameter int NTAPS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick,
  input  logic signed [DW-1:0] din_i,
  input  logic signed [DW-1:0] din_q,
  output logic signed [DW-1:0] dout_i,
  output logic signed [DW-1:0] dout_q,
  output logic                 vld
);

  localparam int LANES = 2;
  localparam int CW    = $clog2(NTAPS);
  localparam logic [CW-1:0] FULL = CW'(NTAPS - 1);

  logic [CW-1:0]        fill;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_out [LANES];

  // Samples held in history since the last clear, saturating once full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fill <= '0;
    else if (clr)                  fill <= '0;
    else if (tick && fill != FULL) fill <= fill + 1'b1;
  end

  assign vld = tick && (fill == FULL);

  assign lane_in[0] = din_i;
  assign lane_in[1] = din_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pwc_fir_lane #(.DW(DW), .NTAPS(NTAPS)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (tick),
      .din  (lane_in[l]),
      .dout (lane_out[l])
    );
  end

  assign dout_i = lane_out[0];
  assign dout_q = lane_out[1];

endmodule

// File: rtl/pwc_decim.sv
module pwc_decim #(
  parameter int FACTOR = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  output logic pass
);

  localparam int CW = (FACTOR > 1) ? $clog2(FACTOR) : 1;
  localparam logic [CW-1:0] LAST = CW'(FACTOR - 1);

  logic [CW-1:0] cnt;

  // Lets through the first of every FACTOR upstream results.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (evt) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign pass = (cnt == '0);

endmodule

// File: rtl/pw_cascade_filter.sv
module pw_cascade_filter
  import pwc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NTAPS = 16,
  parameter int DEC12 = 5,
  parameter int DEC23 = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           sel,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  logic [NSTAGE-1:0] sel_q, en_now, en_old;
  logic [NSTAGE-1:0] st_clr, st_tick, st_vld, st_pass;
  logic signed [DW-1:0] st_in_i  [NSTAGE];
  logic signed [DW-1:0] st_in_q  [NSTAGE];
  logic signed [DW-1:0] st_out_i [NSTAGE];
  logic signed [DW-1:0] st_out_q [NSTAGE];
  logic chg, accept, hit;
  logic signed [DW-1:0] mux_i, mux_q;

  assign en_now   = stage_enables(sel);
  assign en_old   = stage_enables(sel_q);
  assign chg      = (sel != sel_q);
  assign st_clr   = chg ? (en_now & ~en_old) : '0;
  assign in_ready = !chg && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel;
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign st_pass[0] = 1'b1;
      assign st_tick[0] = accept && en_now[0] && st_pass[0];
      assign st_in_i[0] = in_i;
      assign st_in_q[0] = in_q;
    end else begin : g_link
      localparam int FAC = (s == 1) ? DEC12 : DEC23;
      pwc_decim #(.FACTOR(FAC)) u_decim (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_clr[s]),
        .evt  (st_vld[s-1] && en_now[s]),
        .pass (st_pass[s])
      );
      assign st_tick[s] = st_vld[s-1] && en_now[s] && st_pass[s];
      assign st_in_i[s] = st_out_i[s-1];
      assign st_in_q[s] = st_out_q[s-1];
    end

    pwc_stage #(.DW(DW), .NTAPS(NTAPS)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_clr[s]),
      .tick  (st_tick[s]),
      .din_i (st_in_i[s]),
      .din_q (st_in_q[s]),
      .dout_i(st_out_i[s]),
      .dout_q(st_out_q[s]),
      .vld   (st_vld[s])
    );
  end

  // Output selector: the one-hot select picks the stage, a valid select gates it.
  always_comb begin
    hit   = en_now[0] && |(sel & st_vld);
    mux_i = '0;
    mux_q = '0;
    for (int s = 0; s < NSTAGE; s++) begin
      if (sel[s]) begin
        mux_i = st_out_i[s];
        mux_q = st_out_q[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (chg) begin
      out_valid <= 1'b0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (accept && hit) begin
        out_valid <= 1'b1;
        out_i     <= mux_i;
        out_q     <= mux_q;
      end
    end
  end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           sel,
  input logic [2:0]           sel_q,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && (sel == sel_q) |=> out_valid && $stable(out_i) && $stable(out_q)); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R3

  AST_SWITCH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |-> !in_ready); // R9

  AST_SWITCH_DROPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |=> !out_valid); // R9

  AST_BAD_SELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel) != 1) && (sel == sel_q) |-> !out_valid); // R2

  AST_RESULT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R4

endmodule

bind pw_cascade_filter pwc_checker #(.DW(DW)) u_pwc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .sel_q    (sel_q),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_i    (out_i),
  .out_q    (out_q)
);

// File: tb/pw_cascade_filter_test.sv
module pw_cascade_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic gv;
  bit gacc;
  logic signed [DW-1:0] gi, gq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_cascade_filter uut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one sample on a falling edge; read the result one falling edge later.
  task automatic send(input int vi, input int vq);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(vi);
    in_q = DW'(vq);
    gacc = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
    gv = out_valid;
    gi = out_i;
    gq = out_q;
  endtask

  task automatic setsel(input logic [2:0] s);
    @(negedge clk);
    sel = s;
    #1;
    check("R9 input held off in select-change cycle", in_ready, 0);
    @(negedge clk);
    check("R9 input open after select change", in_ready, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid low in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", in_ready, 1);
    check("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_bad_select;
    int nv, na;
    nv = 0; na = 0;
    for (int n = 0; n < 20; n++) begin
      send(1000, 1000);
      nv += int'(gv);
      na += int'(gacc);
    end
    check("R2 select 000 gives no result", nv, 0);
    check("R2 select 000 still accepts", na, 20);
    setsel(3'b011);
    nv = 0; na = 0;
    for (int n = 0; n < 20; n++) begin
      send(1000, 1000);
      nv += int'(gv);
      na += int'(gacc);
    end
    check("R2 select 011 gives no result", nv, 0);
    check("R2 select 011 still accepts", na, 20);
  endtask

  task automatic t_impulse;
    int nv;
    setsel(3'b001);
    nv = 0;
    for (int n = 0; n < 15; n++) begin
      send(0, 0);
      nv += int'(gv);
    end
    check("R8 no result before 16th sample (001)", nv, 0);
    send(1280, -1280);
    check("R8 result on 16th sample (001)", gv, 1);
    check("R5 impulse tap 0", gi, 10);
    check("R11 quadrature mirrors in-phase", gq, -10);
    for (int j = 1; j < 16; j++) begin
      int k;
      k = (j < 8) ? j : 15 - j;
      send(0, 0);
      check("R7 result every sample (001)", gv, 1);
      check("R5 impulse response tap", gi, 10 * (2 * k + 1));
      check("R11 quadrature impulse tap", gq, -10 * (2 * k + 1));
    end
    send(0, 0);
    check("R5 impulse leaves window", gi, 0);
  endtask

  task automatic t_round;
    send(64, -64);
    check("R10 +0.5 rounds up", gi, 1);
    check("R10 -0.5 rounds up", gq, 0);
    send(0, 0);
    check("R10 +1.5 rounds up", gi, 2);
    check("R10 -1.5 rounds up", gq, -1);
  endtask

  task automatic t_stall;
    for (int n = 0; n < 16; n++) send(500, -500);
    check("R6 stage 1 DC gain I", gi, 500);
    check("R6 stage 1 DC gain Q", gq, -500);
    @(negedge clk);
    out_ready = 1'b0;
    send(500, -500);
    check("R3 accepted with room", gacc, 1);
    check("R4 result next edge", gv, 1);
    check("R3 in_ready low while stalled", in_ready, 0);
    send(700, 700);
    check("R3 sample refused while stalled", gacc, 0);
    repeat (3) @(negedge clk);
    check("R3 out_valid held", out_valid, 1);
    check("R3 out_i held", out_i, 500);
    check("R3 out_q held", out_q, -500);
    out_ready = 1'b1;
    @(negedge clk);
    check("R3 result taken", out_valid, 0);
    check("R3 in_ready back", in_ready, 1);
  endtask

  task automatic t_depth(input logic [2:0] s, input int first_exp, input int step,
                         input int total, input int vi, input int vq);
    int first, miss;
    first = 0; miss = 0;
    setsel(3'b000);
    setsel(s);
    for (int n = 1; n <= total; n++) begin
      bit expv;
      send(vi, vq);
      expv = (n >= first_exp) && (((n - first_exp) % step) == 0);
      if (gv !== expv) miss++;
      if (gv && first == 0) begin
        first = n;
        check("R6 DC through cascade I", gi, vi);
        check("R6 DC through cascade Q", gq, vq);
      end
    end
    check("R8 first result index", first, first_exp);
    check("R7 result spacing mismatches", miss, 0);
  endtask

  task automatic t_switch;
    setsel(3'b001);
    send(-900, 300);
    check("R9 kept stage gives result at once", gv, 1);
    check("R9 kept history value I", gi, -900);
    check("R9 kept history value Q", gq, 300);
    out_ready = 1'b0;
    check("R3 pending result present", out_valid, 1);
    setsel(3'b010);
    check("R9 pending result discarded", out_valid, 0);
    out_ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_bad_select();
    t_impulse();
    t_round();
    t_stall();
    t_depth(3'b010, 91, 5, 111, 700, -300);
    t_depth(3'b100, 841, 50, 941, -900, 300);
    t_switch();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule